// File: doc/BRIEF.md
# Paged Address Translator with Access Protection

This block turns a 17-bit virtual word address into a 17-bit actual word address. Memory is split into 512-word pages. The upper eight bits of the virtual address choose one of 256 page slots. Each slot holds an 8-bit actual page number. The nine-bit offset inside the page is passed on unchanged.

Each page slot also carries a 2-bit protection code. Every request is tagged as an instruction fetch, a read or a write. The code decides whether that kind of request is allowed. This check only matters when the processor runs unprivileged (slave mode) with translation switched on. A disallowed request raises a violation flag, so that the surrounding control can hand execution back to the supervisor.

The lowest sixteen virtual words always name general registers. They are never translated and never checked. Both tables are loaded through one write port. That port only works in privileged (master) mode. A write attempted from slave mode is dropped and flagged. A request accepted in cycle t has its results on the outputs in cycle t+1.

Top module: `pagemap_xlate`

## Requirements
- R1: After reset, every page slot holds its own index (identity map), every protection code is 00, and rspValid, accViol and privViol are 0.
- R2: A request with mapEn=1 and vAddr>=16 yields aAddr = {pageSlot[vAddr[16:9]], vAddr[8:0]} on the cycle after the request, with rspValid=1. The low nine offset bits always pass through unchanged.
- R3: A request with vAddr in 0..15 yields aAddr=vAddr and regSpace=1, whatever the values of mapEn and slaveMode. Such a request never raises accViol.
- R4: A request with mapEn=0 yields aAddr=vAddr. For vAddr>=16, regSpace is 0.
- R5: A violation is raised with slaveMode=1, mapEn=1 and vAddr>=16. The request kind is encoded on accType as 00 fetch, 01 read, 10 write, and 11 is treated as a write. The rules per protection code are:
  - code 00 allows every kind;
  - code 01 allows fetch and read but not write;
  - code 10 allows only read;
  - code 11 allows nothing.
- R6: With slaveMode=0, or with mapEn=0, accViol stays 0 for every request.
- R7: A table write with tblWrEn=1 and slaveMode=0 has two forms:
  - with tblSel=0 it stores tblData into page slot tblIdx;
  - with tblSel=1 it stores tblData[1:0] as the protection code of page tblIdx.
  
  Requests from the next cycle on see the new value.
- R8: A table write with slaveMode=1 changes neither table. It raises privViol for exactly one cycle, on the cycle after the write.
- R9: A request issued in the same cycle as a table write to its page is answered from the table contents before that write.
- R10: rspValid is 1 exactly on the cycle after a request (reqValid=1), and accViol is 0 whenever rspValid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Translation request this cycle |
| vAddr | input | 17 | Virtual word address |
| accType | input | 2 | Request kind: 00 fetch, 01 read, 10/11 write |
| mapEn | input | 1 | Translation and protection enabled |
| slaveMode | input | 1 | 1 = unprivileged mode |
| tblWrEn | input | 1 | Table write strobe |
| tblSel | input | 1 | 0 = page slot table, 1 = protection table |
| tblIdx | input | 8 | Page index to write |
| tblData | input | 8 | Page number, or code in bits 1:0 |
| rspValid | output | 1 | Result valid (one cycle after request) |
| aAddr | output | 17 | Actual word address |
| regSpace | output | 1 | Address names a general register |
| accViol | output | 1 | Protection violation for the request |
| privViol | output | 1 | Table write attempted from slave mode |

## Verification
A translation request and a table load can fall in the same cycle, possibly on the same page. The bench provokes this by driving a master-mode write to a page slot and a request to that page in one cycle. It expects the old entry on the response and the new entry on a request issued one cycle later. The same overlap is also driven with a slave-mode write. That response must come from the unchanged table while privViol rises. All expected values come from shadow tables and the encoding rules kept in the bench.

// File: rtl/pagemap_pkg.sv
package pagemap_pkg;

  localparam int PROT_W = 2;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_WRALT = 2'b11
  } accKind_e;

  typedef enum logic [1:0] {
    PROT_OPEN     = 2'b00,
    PROT_NOWRITE  = 2'b01,
    PROT_READONLY = 2'b10,
    PROT_CLOSED   = 2'b11
  } protCode_e;

  typedef struct packed {
    logic capture;
    logic mapLoad;
    logic protLoad;
    logic privErr;
    logic accErr;
  } ctrlStrobe_t;

  function automatic logic accessAllowed(protCode_e code, accKind_e kind);
    logic isWrite;
    isWrite = (kind == ACC_WRITE) || (kind == ACC_WRALT);
    case (code)
      PROT_OPEN:     accessAllowed = 1'b1;
      PROT_NOWRITE:  accessAllowed = !isWrite;
      PROT_READONLY: accessAllowed = (kind == ACC_READ);
      default:       accessAllowed = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pagemap_ctrl.sv
module pagemap_ctrl
  import pagemap_pkg::*;
(
  input  logic        reqValid,
  input  logic [1:0]  accType,
  input  logic        mapEn,
  input  logic        slaveMode,
  input  logic        tblWrEn,
  input  logic        tblSel,
  input  logic        inRegSpace,
  input  protCode_e   pageProt,
  output ctrlStrobe_t strb
);

  logic loadGranted;
  logic checkActive;

  assign loadGranted = tblWrEn && !slaveMode;
  assign checkActive = reqValid && slaveMode && mapEn && !inRegSpace;

  always_comb begin
    strb          = '0;
    strb.capture  = reqValid;
    strb.mapLoad  = loadGranted && !tblSel;
    strb.protLoad = loadGranted && tblSel;
    strb.privErr  = tblWrEn && slaveMode;
    strb.accErr   = checkActive && !accessAllowed(pageProt, accKind_e'(accType));
  end

endmodule

// File: rtl/pagemap_dp.sv
module pagemap_dp
  import pagemap_pkg::*;
#(
  parameter int VA_W      = 17,
  parameter int OFF_W     = 9,
  parameter int REG_WORDS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strb,
  input  logic [VA_W-1:0]       vAddr,
  input  logic                  mapEn,
  input  logic                  reqValid,
  input  logic                  slaveMode,
  input  logic                  tblWrEn,
  input  logic [VA_W-OFF_W-1:0] tblIdx,
  input  logic [VA_W-OFF_W-1:0] tblData,
  output logic                  inRegSpace,
  output protCode_e             pageProt,
  output logic                  rspValid,
  output logic [VA_W-1:0]       aAddr,
  output logic                  regSpace,
  output logic                  accViol,
  output logic                  privViol
);

  localparam int PAGE_W = VA_W - OFF_W;
  localparam int PAGES  = 1 << PAGE_W;

  logic [PAGE_W-1:0] mapTbl  [PAGES];
  logic [PROT_W-1:0] protTbl [PAGES];

  genvar g;
  generate
    for (g = 0; g < PAGES; g++) begin : gEntry
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          mapTbl[g]  <= PAGE_W'(g);
          protTbl[g] <= '0;
        end else begin
          if (strb.mapLoad && tblIdx == PAGE_W'(g))
            mapTbl[g] <= tblData;
          if (strb.protLoad && tblIdx == PAGE_W'(g))
            protTbl[g] <= tblData[PROT_W-1:0];
        end
      end
    end
  endgenerate

  logic [PAGE_W-1:0] pageIdx;
  logic [VA_W-1:0]   xlateAddr;

  assign pageIdx    = vAddr[VA_W-1:OFF_W];
  assign inRegSpace = vAddr < VA_W'(REG_WORDS);
  assign pageProt   = protCode_e'(protTbl[pageIdx]);

  always_comb begin
    if (inRegSpace || !mapEn)
      xlateAddr = vAddr;
    else
      xlateAddr = {mapTbl[pageIdx], vAddr[OFF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      aAddr    <= '0;
      regSpace <= 1'b0;
      accViol  <= 1'b0;
      privViol <= 1'b0;
    end else begin
      rspValid <= strb.capture;
      accViol  <= strb.accErr;
      privViol <= strb.privErr;
      if (strb.capture) begin
        aAddr    <= xlateAddr;
        regSpace <= inRegSpace;
      end
    end
  end

  AST_REG_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (vAddr < VA_W'(REG_WORDS)) |=> regSpace && !accViol && aAddr == $past(vAddr)) // R3
    else $error("register bypass broken");

  AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> aAddr[OFF_W-1:0] == $past(vAddr[OFF_W-1:0])) // R2
    else $error("offset altered");

  AST_NOMAP_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !mapEn |=> aAddr == $past(vAddr)) // R4
    else $error("unmapped address altered");

  AST_MASTER_NO_VIOL: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (!slaveMode || !mapEn) |=> !accViol) // R6
    else $error("violation outside slave mapped mode");

  AST_SLAVE_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    tblWrEn && slaveMode |=> privViol) // R8
    else $error("slave table write not flagged");

  AST_VIOL_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    accViol |-> rspValid) // R10
    else $error("violation without response");

endmodule

// File: rtl/pagemap_xlate.sv
module pagemap_xlate
  import pagemap_pkg::*;
#(
  parameter int VA_W      = 17,
  parameter int OFF_W     = 9,
  parameter int REG_WORDS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [VA_W-1:0]       vAddr,
  input  logic [1:0]            accType,
  input  logic                  mapEn,
  input  logic                  slaveMode,
  input  logic                  tblWrEn,
  input  logic                  tblSel,
  input  logic [VA_W-OFF_W-1:0] tblIdx,
  input  logic [VA_W-OFF_W-1:0] tblData,
  output logic                  rspValid,
  output logic [VA_W-1:0]       aAddr,
  output logic                  regSpace,
  output logic                  accViol,
  output logic                  privViol
);

  ctrlStrobe_t strb;
  logic        inRegSpace;
  protCode_e   pageProt;

  pagemap_ctrl u_ctrl (
    .reqValid   (reqValid),
    .accType    (accType),
    .mapEn      (mapEn),
    .slaveMode  (slaveMode),
    .tblWrEn    (tblWrEn),
    .tblSel     (tblSel),
    .inRegSpace (inRegSpace),
    .pageProt   (pageProt),
    .strb       (strb)
  );

  pagemap_dp #(
    .VA_W      (VA_W),
    .OFF_W     (OFF_W),
    .REG_WORDS (REG_WORDS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .vAddr      (vAddr),
    .mapEn      (mapEn),
    .reqValid   (reqValid),
    .slaveMode  (slaveMode),
    .tblWrEn    (tblWrEn),
    .tblIdx     (tblIdx),
    .tblData    (tblData),
    .inRegSpace (inRegSpace),
    .pageProt   (pageProt),
    .rspValid   (rspValid),
    .aAddr      (aAddr),
    .regSpace   (regSpace),
    .accViol    (accViol),
    .privViol   (privViol)
  );

endmodule

// File: tb/pagemap_xlate_tb.sv
module pagemap_xlate_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [16:0] vAddr = '0;
  logic [1:0]  accType = '0;
  logic        mapEn = 1'b0;
  logic        slaveMode = 1'b0;
  logic        tblWrEn = 1'b0;
  logic        tblSel = 1'b0;
  logic [7:0]  tblIdx = '0;
  logic [7:0]  tblData = '0;
  logic        rspValid;
  logic [16:0] aAddr;
  logic        regSpace;
  logic        accViol;
  logic        privViol;

  int checks = 0;
  int fails = 0;
  logic [7:0] shMap [256];
  logic [1:0] shProt [256];

  always #5 clk = ~clk;

  pagemap_xlate u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .vAddr(vAddr), .accType(accType),
    .mapEn(mapEn), .slaveMode(slaveMode), .tblWrEn(tblWrEn), .tblSel(tblSel),
    .tblIdx(tblIdx), .tblData(tblData), .rspValid(rspValid), .aAddr(aAddr),
    .regSpace(regSpace), .accViol(accViol), .privViol(privViol)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic allowed(input logic [1:0] code, input logic [1:0] kind);
    case (code)
      2'b00: return 1'b1;
      2'b01: return kind[1] == 1'b0;
      2'b10: return kind == 2'b01;
      default: return 1'b0;
    endcase
  endfunction

  // drive a request at a negedge; advance to the next negedge where the result shows
  task automatic doReq(input logic [16:0] va, input logic [1:0] kind, input logic me, input logic sl);
    vAddr = va; accType = kind; mapEn = me; slaveMode = sl; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectResp(input logic [16:0] va, input logic [1:0] kind, input logic me,
                            input logic sl, input string req);
    logic [16:0] ea;
    logic        er;
    logic        ev;
    er = va < 17'd16;
    ea = (er || !me) ? va : {shMap[va[16:9]], va[8:0]};
    ev = sl && me && !er && !allowed(shProt[va[16:9]], kind);
    check({req, " rspValid"}, 32'(rspValid), 32'd1);
    check({req, " aAddr"}, 32'(aAddr), 32'(ea));
    check({req, " regSpace"}, 32'(regSpace), 32'(er));
    check({req, " accViol"}, 32'(accViol), 32'(ev));
  endtask

  task automatic tblWrite(input logic sel, input logic [7:0] idx, input logic [7:0] dat, input logic sl);
    tblWrEn = 1'b1; tblSel = sel; tblIdx = idx; tblData = dat; slaveMode = sl;
    @(negedge clk);
    tblWrEn = 1'b0;
    if (!sl) begin
      if (sel) shProt[idx] = dat[1:0];
      else shMap[idx] = dat;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      shMap[i] = 8'(i);
      shProt[i] = 2'b00;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset output state
    check("R1 rspValid", 32'(rspValid), 32'd0);
    check("R1 accViol", 32'(accViol), 32'd0);
    check("R1 privViol", 32'(privViol), 32'd0);

    // R1/R2: identity map and open codes after reset, slave write request everywhere
    for (int p = 0; p < 256; p++) begin
      logic [16:0] va;
      va = {8'(p), 9'h1A5};
      doReq(va, 2'b10, 1'b1, 1'b1);
      expectResp(va, 2'b10, 1'b1, 1'b1, "R1 identity");
    end

    // R7: master loads of both tables with computed patterns
    for (int p = 0; p < 256; p++) tblWrite(1'b0, 8'(p), 8'(p * 37 + 5), 1'b0);
    for (int p = 0; p < 256; p++) tblWrite(1'b1, 8'(p), 8'(p + 4 * (p / 4)), 1'b0);

    // R2/R5/R7: sweep pages, offsets and all request kinds in slave mapped mode
    for (int p = 0; p < 256; p++) begin
      for (int k = 0; k < 4; k++) begin
        logic [16:0] va;
        va = {8'(p), 9'((p * 13 + k * 101) % 512)};
        if (va < 17'd16) va = va + 17'd16;
        doReq(va, 2'(k), 1'b1, 1'b1);
        expectResp(va, 2'(k), 1'b1, 1'b1, "R2 R5 slave sweep");
      end
    end

    // R6: master mode and map-off never violate; R4 map-off direct
    for (int p = 0; p < 256; p += 3) begin
      logic [16:0] va;
      va = {8'(p), 9'h0F0};
      doReq(va, 2'b10, 1'b1, 1'b0);
      expectResp(va, 2'b10, 1'b1, 1'b0, "R6 master");
      doReq(va, 2'b10, 1'b0, 1'b1);
      expectResp(va, 2'b10, 1'b0, 1'b1, "R4 R6 map off");
    end

    // R3: register addresses with closed page 0, all modes
    tblWrite(1'b1, 8'd0, 8'h03, 1'b0);
    for (int a = 0; a < 16; a++) begin
      for (int m = 0; m < 4; m++) begin
        doReq(17'(a), 2'b10, m[0], m[1]);
        expectResp(17'(a), 2'b10, m[0], m[1], "R3 register");
      end
    end
    doReq(17'd16, 2'b01, 1'b1, 1'b1);
    expectResp(17'd16, 2'b01, 1'b1, 1'b1, "R3 first mapped word");
    check("R3 word16 violates", 32'(accViol), 32'd1);

    // R8: slave writes ignored and flagged one cycle later only
    tblWrite(1'b0, 8'd5, 8'hAA, 1'b1);
    check("R8 privViol", 32'(privViol), 32'd1);
    tblWrite(1'b1, 8'd5, 8'h03, 1'b1);
    check("R8 privViol again", 32'(privViol), 32'd1);
    @(negedge clk);
    check("R8 privViol drop", 32'(privViol), 32'd0);
    doReq({8'd5, 9'h033}, 2'b10, 1'b1, 1'b1);
    expectResp({8'd5, 9'h033}, 2'b10, 1'b1, 1'b1, "R8 tables unchanged");

    // R9: write and request to the same page in one cycle
    tblWrEn = 1'b1; tblSel = 1'b0; tblIdx = 8'd7; tblData = 8'h5C;
    doReq({8'd7, 9'h111}, 2'b01, 1'b1, 1'b0);
    tblWrEn = 1'b0;
    expectResp({8'd7, 9'h111}, 2'b01, 1'b1, 1'b0, "R9 old entry");
    shMap[7] = 8'h5C;
    doReq({8'd7, 9'h111}, 2'b01, 1'b1, 1'b0);
    expectResp({8'd7, 9'h111}, 2'b01, 1'b1, 1'b0, "R9 new entry");
    tblWrEn = 1'b1; tblSel = 1'b1; tblIdx = 8'd7; tblData = 8'h03;
    doReq({8'd7, 9'h040}, 2'b10, 1'b1, 1'b1);
    tblWrEn = 1'b0;
    expectResp({8'd7, 9'h040}, 2'b10, 1'b1, 1'b1, "R9 slave overlap");
    check("R9 R8 privViol overlap", 32'(privViol), 32'd1);

    // R10: no request, no response
    @(negedge clk);
    check("R10 rspValid idle", 32'(rspValid), 32'd0);
    check("R10 accViol idle", 32'(accViol), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule